// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block moves one byte at a time over a two-wire I2C bus under the control of a small 32-bit register window. Software sets a 16-bit clock divider and four control bits: enable, acknowledge level, stop request and start request. It then writes the transmit-data register. That write launches the transfer. If the start request is set, a start condition (or a repeated start, when the bus is still held from an earlier byte) comes first. Eight data bits follow, most significant bit first, and then the acknowledge slot. If the stop request is set, a stop condition comes last. Otherwise the bus stays owned, with SCL held low.

Both bus lines are open-drain. Each `*_oe` output, when high, pulls its line low. SDA is also read back through `sda_in`. SCL is only driven, because slaves cannot stretch the clock. Each half-phase of SCL lasts `max(P,1)+1` system clocks, where P is the divider value. At completion the hardware clears the start request and sets a read-only completion flag. This lets software arm the next byte simply by setting control bits.

The register bus has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `i2c_byte_master`

## Requirements
- R1: An SCL half-phase lasts max(P,1)+1 clock cycles, so one SCL period is 2*(max(P,1)+1) cycles, where P is the divider at byte offset 0x0.
- R2: After reset the divider reads 0x000001F3 and bits 31:16 of that register read zero. Control and status read 0, and neither bus line is pulled.
- R3: A divider write is accepted only when all four byte enables are set. Any other enable pattern leaves the divider unchanged.
- R4: Control (offset 0x4) holds enable in bit 0, acknowledge level in bit 1, stop request in bit 2 and start request in bit 3. Bits 31:4 read zero.
- R5: A write to transmit data (offset 0xC) while enabled and idle launches a transfer. Bits 7:0 are the byte and bit 8 selects receive. With the start request set, SDA falls while SCL is high, and then the byte follows MSB first.
- R6: The cycle after an accepted launch, status (offset 0x8) shows busy (bit 0) = 1 and completion (bit 1) = 0.
- R7: At completion, busy drops and completion rises in the same cycle, and the start request reads 0.
- R8: With the stop request set, SDA rises while SCL is high after the acknowledge slot, and the stop request reads 0 afterwards. Without it, SCL stays pulled low, SDA is released, and the next start becomes a repeated start.
- R9: The SDA level seen in the ninth SCL high phase is stored in status bit 2 (0 = acknowledge).
- R10: In receive mode, SDA is released for the eight data bits and the sampled byte appears in status bits 15:8, MSB first. In the acknowledge slot, SDA is pulled low when the acknowledge level is 0 and released when it is 1.
- R11: Clearing enable releases both lines and returns to idle within one cycle, without setting completion. Transmit writes made while disabled or busy are ignored.
- R12: During a data or acknowledge bit, SDA changes only while SCL is low. Start and stop are the only SDA edges while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The hardest state to reach is a repeated start. It only occurs after a byte ends without a stop, leaving SCL held low, and the next launch then carries a start request. The sweep alternates the stop request across consecutive bytes so that about half of the starts are repeated starts, and one byte is sent with no start at all from the held state. The abort case is reached by clearing enable partway through a slow byte. A bus-level slave model counts starts, stops and bits on the wire, so any stray SDA edge while SCL is high shows up as a count mismatch.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [3:0] OFS_DIV  = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_TXD  = 4'hC;

  localparam int CB_EN    = 0;
  localparam int CB_ACK   = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_START = 3;

  typedef struct packed {
    logic start;
    logic stop;
    logic ack_lvl;
    logic en;
  } ctrl_t;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RS_LOW,
    PH_ST_HIGH,
    PH_ST_SDA,
    PH_BIT_LO,
    PH_BIT_HI,
    PH_SP_LO,
    PH_SP_HI,
    PH_SP_REL
  } phase_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_eff;

  // a half-phase is never shorter than two cycles
  assign lim_eff = (limit == '0) ? DIV_W'(1) : limit;
  assign tick    = run && !clr && (cnt >= lim_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (clr || !run || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R1: two ticks never arrive back to back
  assert_no_double_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs import i2cm_pkg::*; #(
  parameter int              BUS_W   = 32,
  parameter int              DIV_W   = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 16'h01F3,
  parameter int              BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [BUS_W/8-1:0] be,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output ctrl_t             ctl,
  output logic [DIV_W-1:0]  div,
  output logic              accept,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_rd,
  input  logic              busy,
  input  logic              finish,
  input  logic              clr_start,
  input  logic              clr_stop,
  input  logic              ack_rcv,
  input  logic [BYTE_W-1:0] rx_byte
);
  localparam int STAT_W = BYTE_W + 8;

  logic ctl_wr;
  logic div_wr;
  logic done;
  logic [STAT_W-1:0] stat_word;
  wire unused_wdata = ^wdata[BUS_W-1:DIV_W];

  assign ctl_wr  = wr_en && (addr == OFS_CTRL);
  assign div_wr  = wr_en && (addr == OFS_DIV) && (be == '1);
  assign accept  = wr_en && (addr == OFS_TXD) && ctl.en && !busy;
  assign tx_byte = wdata[BYTE_W-1:0];
  assign tx_rd   = wdata[BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= '0;
      div  <= DIV_RST;
      done <= 1'b0;
    end else begin
      if (div_wr) div <= wdata[DIV_W-1:0];
      if (ctl_wr) begin
        ctl.en      <= wdata[CB_EN];
        ctl.ack_lvl <= wdata[CB_ACK];
        ctl.stop    <= wdata[CB_STOP];
        ctl.start   <= wdata[CB_START];
      end
      if (clr_start) ctl.start <= 1'b0;
      if (clr_stop)  ctl.stop  <= 1'b0;
      if (accept)      done <= 1'b0;
      else if (finish) done <= 1'b1;
    end
  end

  assign stat_word = {rx_byte, 5'b0, ack_rcv, done, busy};

  always_comb begin
    unique case (addr)
      OFS_DIV:  rdata = BUS_W'(div);
      OFS_CTRL: rdata = BUS_W'({ctl.start, ctl.stop, ctl.ack_lvl, ctl.en});
      OFS_STAT: rdata = BUS_W'(stat_word);
      default:  rdata = '0;
    endcase
  end

  assert_div_fullword_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DIV && be != '1) |=> $stable(div));
  assert_launch_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !done));
  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> done);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              launch,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_rd,
  input  logic              use_start,
  input  logic              use_stop,
  input  logic              ack_lvl,
  input  logic              sda_in,
  output logic              busy,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              finish,
  output logic              clr_start,
  output logic              clr_stop,
  output logic              ack_rcv,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BCW = $clog2(BYTE_W + 1);
  localparam logic [BCW-1:0] ACK_SLOT = BCW'(BYTE_W);

  phase_t           st;
  logic             held;
  logic             rd;
  logic             start_lat;
  logic             ack_lat;
  logic [BYTE_W-1:0] shreg;
  logic [BCW-1:0]   bcnt;
  logic             bit_pull;
  logic             sda_pull;
  logic             last_slot;

  assign busy      = (st != PH_IDLE);
  assign last_slot = (bcnt == ACK_SLOT);
  assign finish    = en && tick &&
                     ((st == PH_BIT_HI && last_slot && !use_stop) || st == PH_SP_REL);
  assign clr_start = finish && start_lat;
  assign clr_stop  = en && tick && (st == PH_SP_REL);

  always_comb begin
    if (last_slot) bit_pull = rd ? !ack_lat : 1'b0;
    else           bit_pull = rd ? 1'b0 : !shreg[BYTE_W-1];
  end

  always_comb begin
    scl_oe   = 1'b0;
    sda_pull = 1'b0;
    unique case (st)
      PH_IDLE:    scl_oe = held;
      PH_RS_LOW:  scl_oe = 1'b1;
      PH_ST_HIGH: ;
      PH_ST_SDA:  sda_pull = 1'b1;
      PH_BIT_LO:  begin scl_oe = 1'b1; sda_pull = bit_pull; end
      PH_BIT_HI:  sda_pull = bit_pull;
      PH_SP_LO:   begin scl_oe = 1'b1; sda_pull = 1'b1; end
      PH_SP_HI:   sda_pull = 1'b1;
      default:    ;
    endcase
  end

  // SDA trails the phase by one cycle so it never moves on an SCL edge
  always_ff @(posedge clk) begin
    if (!rst_n) sda_oe <= 1'b0;
    else        sda_oe <= en && sda_pull;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      held      <= 1'b0;
      rd        <= 1'b0;
      start_lat <= 1'b0;
      ack_lat   <= 1'b1;
      shreg     <= '0;
      bcnt      <= '0;
      ack_rcv   <= 1'b0;
      rx_byte   <= '0;
    end else if (!en) begin
      st   <= PH_IDLE;
      held <= 1'b0;
    end else begin
      unique case (st)
        PH_IDLE: if (launch) begin
          shreg     <= tx_byte;
          rd        <= tx_rd;
          start_lat <= use_start;
          ack_lat   <= ack_lvl;
          bcnt      <= '0;
          if (use_start) st <= held ? PH_RS_LOW : PH_ST_HIGH;
          else           st <= PH_BIT_LO;
        end
        PH_RS_LOW:  if (tick) st <= PH_ST_HIGH;
        PH_ST_HIGH: if (tick) st <= PH_ST_SDA;
        PH_ST_SDA:  if (tick) st <= PH_BIT_LO;
        PH_BIT_LO:  if (tick) st <= PH_BIT_HI;
        PH_BIT_HI: if (tick) begin
          if (last_slot) begin
            ack_rcv <= sda_in;
            if (use_stop) st <= PH_SP_LO;
            else begin
              st   <= PH_IDLE;
              held <= 1'b1;
            end
          end else begin
            if (rd) rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
            shreg <= shreg << 1;
            bcnt  <= bcnt + 1'b1;
            st    <= PH_BIT_LO;
          end
        end
        PH_SP_LO: if (tick) st <= PH_SP_HI;
        PH_SP_HI: if (tick) st <= PH_SP_REL;
        PH_SP_REL: if (tick) begin
          st   <= PH_IDLE;
          held <= 1'b0;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assert_abort_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == PH_IDLE && !scl_oe && !sda_oe));
  assert_sda_still_in_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_BIT_HI && $past(st) == PH_BIT_HI) |-> $stable(sda_oe));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master import i2cm_pkg::*; #(
  parameter int              DIV_W   = 16,
  parameter logic [DIV_W-1:0] DIV_RST = 16'h01F3,
  parameter int              BYTE_W  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in
);
  localparam int BUS_W = 32;

  ctrl_t             ctl;
  logic [DIV_W-1:0]  div;
  logic              accept;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_rd;
  logic              busy;
  logic              finish;
  logic              clr_start;
  logic              clr_stop;
  logic              ack_rcv;
  logic [BYTE_W-1:0] rx_byte;
  logic              tick;

  i2cm_regs #(
    .BUS_W(BUS_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST), .BYTE_W(BYTE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .be(bus_be),
    .wdata(bus_wdata), .rdata(bus_rdata), .ctl(ctl), .div(div),
    .accept(accept), .tx_byte(tx_byte), .tx_rd(tx_rd), .busy(busy),
    .finish(finish), .clr_start(clr_start), .clr_stop(clr_stop),
    .ack_rcv(ack_rcv), .rx_byte(rx_byte)
  );

  i2cm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .clr(accept), .limit(div), .tick(tick)
  );

  i2cm_engine #(.BYTE_W(BYTE_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(ctl.en), .tick(tick), .launch(accept),
    .tx_byte(tx_byte), .tx_rd(tx_rd), .use_start(ctl.start),
    .use_stop(ctl.stop), .ack_lvl(ctl.ack_lvl), .sda_in(sda_in),
    .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe), .finish(finish),
    .clr_start(clr_start), .clr_stop(clr_stop), .ack_rcv(ack_rcv),
    .rx_byte(rx_byte)
  );
endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        scl_oe, sda_oe, sda_in;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // bus and slave model
  logic slv_pull;
  logic slv_ack_en = 1'b0;
  logic slv_ack = 1'b0;
  int   rd_left = 0;
  logic [7:0] rd_byte = '0;
  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_pull);
  assign sda_in = sda_line;

  int idx = -1;
  int n_start = 0, n_stop = 0, n_bytes = 0;
  int t_rise1 = 0, per = 0;
  logic [7:0] mon_sh = '0, mon_byte = '0;
  logic mon_ack = 1'b1;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always @(scl_line or sda_line) begin
    if (p_scl === 1'b1 && scl_line === 1'b1 && p_sda === 1'b1 && sda_line === 1'b0) begin
      n_start++; idx = -1;
    end
    if (p_scl === 1'b1 && scl_line === 1'b1 && p_sda === 1'b0 && sda_line === 1'b1)
      n_stop++;
    if (p_scl === 1'b1 && scl_line === 1'b0) idx = (idx >= 8) ? 0 : idx + 1;
    if (p_scl === 1'b0 && scl_line === 1'b1) begin
      if (idx >= 0 && idx < 8) mon_sh = {mon_sh[6:0], sda_line};
      if (idx == 1) t_rise1 = cyc;
      if (idx == 2) per = cyc - t_rise1;
      if (idx == 8) begin
        mon_byte = mon_sh; mon_ack = sda_line; n_bytes++;
        if (rd_left > 0) rd_left--;
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  always_comb begin
    slv_pull = 1'b0;
    if (slv_ack_en && idx == 8 && !slv_ack) slv_pull = 1'b1;
    if (rd_left > 0 && idx >= 0 && idx < 8 && !rd_byte[3'(7 - idx)]) slv_pull = 1'b1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      bus_read(4'h8, s);
      if (!s[0]) return;
    end
    check("R7 busy never dropped", 32'd1, 32'd0);
  endtask

  task automatic xfer(input int p, input logic [7:0] d, input logic rd,
                      input logic st, input logic sp, input logic ackl, input logic sack);
    logic [31:0] s, c;
    int s0, p0, b0, eh;
    bus_write(4'h0, 32'(p), 4'hF);
    bus_write(4'h4, {28'b0, st, sp, ackl, 1'b1}, 4'hF);
    slv_ack_en = !rd; slv_ack = sack;
    rd_byte = d; rd_left = rd ? 1 : 0;
    idx = st ? -1 : 0;
    s0 = n_start; p0 = n_stop; b0 = n_bytes;
    bus_write(4'hC, {23'b0, rd, d}, 4'hF);
    bus_read(4'h8, s);
    check("R6 busy after launch", 32'(s[0]), 32'd1);
    check("R6 done cleared by launch", 32'(s[1]), 32'd0);
    wait_idle();
    bus_read(4'h8, s);
    bus_read(4'h4, c);
    eh = (p < 1) ? 1 : p;
    check("R5 one byte on the bus", 32'(n_bytes - b0), 32'd1);
    // spurious SDA edges with SCL high would disturb these counts (R12)
    check("R5 R12 start count", 32'(n_start - s0), 32'(st));
    check("R8 R12 stop count", 32'(n_stop - p0), 32'(sp));
    check("R1 SCL period", 32'(per), 32'(2 * (eh + 1)));
    check("R7 done set", 32'(s[1]), 32'd1);
    check("R7 R8 start and stop cleared", c, {28'b0, 1'b0, 1'b0, ackl, 1'b1});
    if (rd) begin
      check("R10 received byte", 32'(s[15:8]), 32'(d));
      check("R10 master ack level", 32'(mon_ack), 32'(ackl));
    end else begin
      check("R5 byte MSB first", 32'(mon_byte), 32'(d));
      check("R9 ack stored", 32'(s[2]), 32'(sack));
    end
    if (!sp) begin
      @(negedge clk); @(negedge clk);
      check("R8 SCL held low", 32'(scl_oe), 32'd1);
      check("R8 SDA released", 32'(sda_oe), 32'd0);
    end
    slv_ack_en = 1'b0; rd_left = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_start = 0; n_stop = 0; n_bytes = 0;

    bus_read(4'h0, r); check("R2 divider reset", r, 32'h1F3);
    bus_read(4'h4, r); check("R2 control reset", r, 32'h0);
    bus_read(4'h8, r); check("R2 status reset", r, 32'h0);
    check("R2 lines released", {30'b0, scl_oe, sda_oe}, 32'h0);

    for (int m = 0; m < 15; m++) begin
      bus_write(4'h0, 32'h0000_0055, 4'(m));
      bus_read(4'h0, r); check("R3 partial divider write ignored", r, 32'h1F3);
    end
    bus_write(4'h0, 32'hABCD_0007, 4'hF);
    bus_read(4'h0, r); check("R2 R3 full write, upper zero", r, 32'h7);

    bus_write(4'h4, 32'hFFFF_FFFF, 4'hF);
    bus_read(4'h4, r); check("R4 control bits", r, 32'hF);
    bus_write(4'h4, 32'h0, 4'hF);
    bus_read(4'h4, r); check("R4 control clear", r, 32'h0);

    // R11: transmit write while disabled
    bus_write(4'hC, 32'h0000_00AA, 4'hF);
    bus_read(4'h8, r); check("R11 disabled write ignored", 32'(r[0]), 32'd0);
    repeat (10) @(negedge clk);
    check("R11 lines idle when disabled", {30'b0, scl_oe, sda_oe}, 32'h0);

    // write sweep; stop alternates so repeated starts occur
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        xfer(p, 8'(k * 73 + p * 29 + 1), 1'b0, 1'b1, k[1], 1'b0, k[0]);
    // continuation byte without start from the held bus
    xfer(2, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    xfer(2, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // receive sweep
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 4; k++)
        xfer(p, 8'(k * 91 + p * 17 + 6), 1'b1, 1'b1, 1'b1, k[0], 1'b0);

    // R11: a transmit write while busy is ignored
    bus_write(4'h0, 32'd2, 4'hF);
    bus_write(4'h4, 32'hD, 4'hF);
    slv_ack_en = 1'b1; slv_ack = 1'b0; idx = -1;
    r = 32'(n_bytes);
    bus_write(4'hC, 32'h3C, 4'hF);
    bus_write(4'hC, 32'hFF, 4'hF);
    wait_idle();
    check("R11 busy write ignored, byte", 32'(mon_byte), 32'h3C);
    check("R11 busy write ignored, count", 32'(n_bytes) - r, 32'd1);
    slv_ack_en = 1'b0;

    // R11: abort mid-byte
    bus_write(4'h0, 32'd3, 4'hF);
    bus_write(4'h4, 32'hD, 4'hF);
    idx = -1;
    bus_write(4'hC, 32'h00, 4'hF);
    repeat (30) @(negedge clk);
    bus_write(4'h4, 32'h0, 4'hF);
    @(negedge clk);
    check("R11 abort releases lines", {30'b0, scl_oe, sda_oe}, 32'h0);
    bus_read(4'h8, r);
    check("R11 abort busy", 32'(r[0]), 32'd0);
    check("R11 abort no done", 32'(r[1]), 32'd0);
    repeat (5) @(negedge clk);
    xfer(1, 8'h96, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule